// File: doc/BRIEF.md
# Register Reuse Predictor with Clearing Counters

This block guesses, early in the pipeline, whether an instruction will write the same value that its destination register already holds. Dependents of such an instruction can then go ahead without waiting for its result. It keeps a table of 3-bit confidence counters. A field of low instruction-address bits selects one counter. A counter climbs by one each time its instruction commits with a repeated value. It drops straight back to zero the first time the value changes.

A lookup is combinational. It reports a prediction in the same cycle that the address is presented. The prediction is given only when the selected counter has reached its ceiling. An update arrives at commit time with the address, the instruction class and the outcome of the value comparison. The table is written on that clock edge.

Stores and control-flow instructions are never predicted and never train the table. The `USE_HIST` parameter selects a global-history variant. In that variant the table index is the address field XORed with a shift register. The shift register holds the outcomes of recent eligible commits.

Top module: `reg_reuse_pred`

## Requirements
- R1: After reset every counter is zero, so no lookup predicts for any address until training has occurred.
- R2: A valid update with an eligible class and `up_redundant`=1 raises the selected counter by one.
- R3: A counter already at 7 stays at 7 on further redundant updates.
- R4: A valid update with an eligible class and `up_redundant`=0 clears the selected counter to zero, whatever its previous count.
- R5: `lk_pred` is 1 only when the selected counter is strictly above 6, that is equal to 7. A count of 6 gives no prediction.
- R6: Class code 2'b11 (store or control flow) is ineligible. A lookup with that class gives `lk_pred`=0, and an update with that class changes neither the counters nor the history. Codes 2'b00 (load), 2'b01 (integer arithmetic) and 2'b10 (floating-point arithmetic) are eligible.
- R7: An update with `up_valid`=0 changes no state.
- R8: The table index is `pc[PC_LSB+IDX_W-1:PC_LSB]`. Addresses that agree in that field share a counter, and all other address bits are ignored.
- R9: When a lookup and an update hit the same entry in one cycle, the lookup reports the count from before that update. The update is visible to lookups from the next cycle on.
- R10: With `USE_HIST`=1, the index is the R8 field XOR the zero-extended `HIST_W`-bit history. The history resets to zero. Each eligible valid update shifts the history left and inserts `up_redundant` at bit 0. That update itself indexes with the history as it stood before the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the instruction being looked up |
| lk_cls | input | 2 | Class of the looked-up instruction |
| lk_pred | output | 1 | 1 = predicted to rewrite the value already in its destination |
| up_valid | input | 1 | Commit update present |
| up_pc | input | PC_W | Address of the committing instruction |
| up_cls | input | 2 | Class of the committing instruction |
| up_redundant | input | 1 | 1 = the committed result equalled the old destination value |

## Verification
A prediction is due in the same cycle as its lookup, because no register lies between the lookup address and `lk_pred`. An update takes effect at the next rising edge and can first be seen by a lookup in the cycle after it was presented. The bench drives both ports on the falling edge and samples `lk_pred` shortly after. It then advances its reference counters and history as the rising edge would. Every comparison therefore sees pre-update state, and this matches R9 directly. Two instances run side by side on the same stimulus, one with history indexing and one without.

// File: rtl/reg_reuse_pred.sv
module reg_reuse_pred #(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_W    = 6,
  parameter bit USE_HIST = 1'b0,
  parameter int HIST_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [1:0]      lk_cls,
  output logic            lk_pred,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic [1:0]      up_cls,
  input  logic            up_redundant
);
  localparam int         DEPTH  = 1 << IDX_W;
  localparam logic [2:0] CMAX   = 3'd7;
  localparam logic [2:0] THRESH = 3'd6;
  localparam logic [1:0] CLS_NO = 2'b11;

  logic [2:0]       tbl [DEPTH];
  logic [IDX_W-1:0] hmix, lk_idx, up_idx;
  logic [2:0]       cur, nxt;
  logic             up_ok;
  logic             unused_bits;

  assign unused_bits = ^{lk_pc[PC_W-1:PC_LSB+IDX_W], lk_pc[PC_LSB-1:0],
                         up_pc[PC_W-1:PC_LSB+IDX_W], up_pc[PC_LSB-1:0]};

  assign up_ok  = up_valid && (up_cls != CLS_NO);
  assign lk_idx = lk_pc[PC_LSB +: IDX_W] ^ hmix;
  assign up_idx = up_pc[PC_LSB +: IDX_W] ^ hmix;
  assign cur    = tbl[up_idx];
  assign nxt    = !up_redundant ? 3'd0 : (cur == CMAX) ? CMAX : cur + 3'd1;
  assign lk_pred = (lk_cls != CLS_NO) && (tbl[lk_idx] > THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= 3'd0;
    end else if (up_ok) begin
      tbl[up_idx] <= nxt;
    end
  end

  generate
    if (USE_HIST) begin : g_hist
      logic [HIST_W-1:0] hist;
      always_ff @(posedge clk) begin
        if (!rst_n)     hist <= '0;
        else if (up_ok) hist <= {hist[HIST_W-2:0], up_redundant};
      end
      assign hmix = IDX_W'(hist);

      p_hist_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        up_ok |=> hist == {$past(hist[HIST_W-2:0]), $past(up_redundant)});
      p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !up_ok |=> $stable(hist));
    end else begin : g_pc
      assign hmix = '0;
    end
  endgenerate

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ok && up_redundant && cur != CMAX) |=> tbl[$past(up_idx)] == $past(cur) + 3'd1);
  p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ok && up_redundant && cur == CMAX) |=> tbl[$past(up_idx)] == CMAX);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ok && !up_redundant) |=> tbl[$past(up_idx)] == 3'd0);
  p_pred_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_pred |-> tbl[lk_idx] == CMAX);
  p_no_pred_ineligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_cls == CLS_NO) |-> !lk_pred);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ok |=> tbl[$past(up_idx)] == $past(cur));
endmodule

// File: tb/sim_reg_reuse_pred.sv
module sim_reg_reuse_pred;
  localparam int PERIOD = 10;
  localparam int PC_W = 32, PC_LSB = 2, IDX_W = 6, HIST_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic [1:0] lk_cls = 0, up_cls = 0;
  logic up_valid = 0, up_redundant = 0;
  logic pred0, pred1;

  int m0 [DEPTH];
  int m1 [DEPTH];
  logic [HIST_W-1:0] mh;
  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  reg_reuse_pred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .USE_HIST(1'b0), .HIST_W(HIST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_cls(lk_cls), .lk_pred(pred0),
    .up_valid(up_valid), .up_pc(up_pc), .up_cls(up_cls), .up_redundant(up_redundant));
  reg_reuse_pred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .USE_HIST(1'b1), .HIST_W(HIST_W)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_cls(lk_cls), .lk_pred(pred1),
    .up_valid(up_valid), .up_pc(up_pc), .up_cls(up_cls), .up_redundant(up_redundant));

  function automatic int ix0(logic [PC_W-1:0] pc);
    return int'(pc[PC_LSB +: IDX_W]);
  endfunction
  function automatic int ix1(logic [PC_W-1:0] pc, logic [HIST_W-1:0] h);
    return int'(pc[PC_LSB +: IDX_W] ^ IDX_W'(h));
  endfunction
  function automatic bit exp_pred(int cnt, logic [1:0] cls);
    return (cls != 2'b11) && (cnt > 6);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [PC_W-1:0] lpc, logic [1:0] lcls,
                     bit v, logic [PC_W-1:0] upc, logic [1:0] ucls, bit red);
    @(negedge clk);
    lk_pc = lpc; lk_cls = lcls; up_valid = v; up_pc = upc; up_cls = ucls; up_redundant = red;
    #1;
    chk(pred0, exp_pred(m0[ix0(lpc)], lcls), "pc-indexed");
    chk(pred1, exp_pred(m1[ix1(lpc, mh)], lcls), "history-indexed");
    if (v && ucls != 2'b11) begin
      int a = ix0(upc);
      int b = ix1(upc, mh);
      m0[a] = red ? ((m0[a] == 7) ? 7 : m0[a] + 1) : 0;
      m1[b] = red ? ((m1[b] == 7) ? 7 : m1[b] + 1) : 0;
      mh = {mh[HIST_W-2:0], red};
    end
  endtask

  task automatic look(logic [PC_W-1:0] pc, logic [1:0] cls);
    cyc(pc, cls, 0, 0, 0, 0);
  endtask
  task automatic train(logic [PC_W-1:0] pc, logic [1:0] cls, bit red);
    cyc(pc, cls, 1, pc, cls, red);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin m0[i] = 0; m1[i] = 0; end
    mh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    tag = "R1";
    for (int i = 0; i < DEPTH; i++) look(32'(i << PC_LSB), 2'b00);

    tag = "R2";
    for (int i = 0; i < 5; i++) train(32'h100, 2'b01, 1);
    look(32'h100, 2'b01);

    tag = "R5";
    train(32'h100, 2'b01, 1);
    look(32'h100, 2'b01);
    train(32'h100, 2'b01, 1);
    look(32'h100, 2'b01);

    tag = "R3";
    for (int i = 0; i < 4; i++) train(32'h100, 2'b10, 1);
    look(32'h100, 2'b10);

    tag = "R6";
    look(32'h100, 2'b11);
    cyc(32'h100, 2'b00, 1, 32'h100, 2'b11, 0);
    look(32'h100, 2'b00);

    tag = "R7";
    cyc(32'h100, 2'b00, 0, 32'h100, 2'b00, 0);
    look(32'h100, 2'b00);

    tag = "R8";
    look(32'hABC0_0100, 2'b00);
    look(32'h0000_0101, 2'b00);

    tag = "R9";
    cyc(32'h100, 2'b00, 1, 32'h100, 2'b00, 0);
    look(32'h100, 2'b00);

    tag = "R4";
    for (int i = 0; i < 7; i++) train(32'h200, 2'b00, 1);
    train(32'h200, 2'b00, 0);
    look(32'h200, 2'b00);

    tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] lp = 32'({$urandom_range(0, 15)} << PC_LSB) | 32'($urandom_range(0, 3));
      logic [PC_W-1:0] upc = 32'({$urandom_range(0, 15)} << PC_LSB) ^ ($urandom & 32'hFF00_0000);
      logic [1:0] lc = 2'($urandom_range(0, 3));
      logic [1:0] uc = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      bit v = ($urandom_range(0, 4) != 0);
      bit r = ($urandom_range(0, 19) != 0);
      cyc(lp, lc, v, upc, uc, r);
    end
    finish_run();
  end
endmodule